// File: doc/BRIEF.md
# Keyboard Controller Command Sequencer

This block runs one complete transaction on a PS/2-style keyboard controller on behalf of a host. It talks to the controller through a status byte, a command-register write strobe, a data-register write strobe and a data-register read strobe. A 16-bit command word packs three things together. The low byte is the opcode. The top nibble is how many parameter bytes follow the opcode. The nibble below it is how many response bytes to collect.

On a start pulse the sequencer loads a 15-byte buffer with the caller's parameters. It writes the opcode, then each parameter byte in buffer order. It then reads each response byte back into the same buffer, starting at slot 0. Every write waits for the controller's input buffer to drain, and every read waits for its output buffer to fill. Each wait polls the status at a fixed cycle interval. If too many checks fail, the transaction is abandoned.

For the loopback opcode, every response byte must be marked as coming from the auxiliary device. When the loopback-disable input is high, a loopback opcode is refused at once. The transaction ends with either a one-cycle done pulse or a one-cycle error pulse that carries a code.

Top module: `kbc_cmd_seq`

## Requirements
- R1: After reset the block is idle: busy, done, err and all three strobes are low, and err_code is 0.
- R2: The first access of every transaction writes cmd_word[7:0] through kbc_cmd_wr. The write happens only in a cycle where status bit 1 (input buffer full) is clear.
- R3: Exactly cmd_word[15:12] parameter bytes then go out through kbc_data_wr, taken from buffer slots 0, 1, 2 and so on in order. Each write happens only while status bit 1 is clear.
- R4: Exactly cmd_word[11:8] bytes are then read with kbc_data_rd, and each read happens only while status bit 0 (output buffer full) is set. The read bytes land in buffer slots 0, 1, 2 and so on, and slots that are not read keep their loaded values.
- R5: Each wait checks the status in its first cycle and then every POLL_GAP cycles. The wait fails when MAX_POLLS checks have all failed. In that case err pulses with code 1 in the following cycle, and no further access is made.
- R6: For opcode LOOP_OP (default 0xD3), a response check that finds status bit 0 set but status bit 5 (auxiliary source) clear ends the transaction. No read strobe is issued, and err pulses with code 2 in the next cycle.
- R7: With loop_disable high, a LOOP_OP command raises err with code 3 in the cycle after start, with no strobe at all. Other opcodes are not affected by loop_disable.
- R8: A command with zero parameter and zero response bytes pulses done in the cycle right after the command strobe.
- R9: start is taken only while busy is low. busy is high from the cycle after an accepted start through the cycle of its done or err pulse. done and err last one cycle each and never occur together.
- R10: At most one of the three controller strobes is high in any cycle, and only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transaction (taken when idle) |
| cmd_word | input | 16 | Write count, read count and opcode |
| param_in | input | 120 | Parameter bytes, slot 0 in bits 7:0 |
| loop_disable | input | 1 | Refuse the loopback opcode |
| kbc_status | input | 8 | Controller status byte |
| kbc_rdata | input | 8 | Controller data register read value |
| kbc_cmd_wr | output | 1 | Command register write strobe |
| kbc_data_wr | output | 1 | Data register write strobe |
| kbc_wdata | output | 8 | Byte written with either write strobe |
| kbc_data_rd | output | 1 | Data register read strobe |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | One-cycle failure pulse |
| err_code | output | 2 | 1 timeout, 2 wrong source, 3 refused; 0 otherwise |
| buf_out | output | 120 | Buffer contents, slot 0 in bits 7:0 |

## Verification
Several properties are checked every cycle. Each strobe must respect its status flag. Only one strobe may be active at a time, and strobes may appear only while busy. The done and err pulses must be single-cycle and exclusive. A refusal must follow a start taken while idle.

Other behaviour can only be shown by the bench's scenarios. These cover the exact order and values of the bytes written, where the read bytes land in the buffer, and the poll spacing and cycle at which a timeout fires. They also cover the abort on a wrong response source, and the fact that a start arriving mid-transaction is ignored.

// File: rtl/kbcs_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the keyboard controller command
// sequencer. Assumes the command word layout {n_wr, n_rd, opcode}.
package kbcs_pkg;
    localparam int CNT_W  = 4;
    localparam int BYTE_W = 8;
    localparam int BUF_N  = (1 << CNT_W) - 1;
    localparam int BUF_BITS = BUF_N * BYTE_W;
    localparam int IDX_W  = CNT_W;

    // Status bit positions decoded by the sequencer.
    localparam int ST_OBF = 0;
    localparam int ST_IBF = 1;
    localparam int ST_AUX = 5;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_TIMEOUT = 2'd1,
        ERR_SOURCE  = 2'd2,
        ERR_REJECT  = 2'd3
    } err_code_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_PARAM,
        PH_RESP,
        PH_FIN
    } phase_t;

    typedef struct packed {
        logic [CNT_W-1:0]  n_wr;
        logic [CNT_W-1:0]  n_rd;
        logic [BYTE_W-1:0] op;
    } cmd_word_t;
endpackage

// File: rtl/kbcs_poll_timer.sv
`timescale 1ns/1ps
// Module: poll spacing and poll budget for one status wait.
// A check is due whenever the gap counter is zero. Each failed check
// restarts the gap and uses up one poll. expired flags the failed check
// that exhausts the budget. Assumes POLL_GAP >= 1 and MAX_POLLS >= 1.
module kbcs_poll_timer #(
    parameter int POLL_GAP  = 50,
    parameter int MAX_POLLS = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic miss,
    output logic check_now,
    output logic expired
);
    localparam int GAP_W  = (POLL_GAP  > 1) ? $clog2(POLL_GAP)  : 1;
    localparam int POLL_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;

    logic [GAP_W-1:0]  gap_q;
    logic [POLL_W-1:0] polls_q;

    assign check_now = (gap_q == '0);
    assign expired   = check_now && miss && (polls_q == POLL_W'(MAX_POLLS - 1));

    // Count the gap between checks and the number of failed checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q   <= '0;
            polls_q <= '0;
        end else if (restart) begin
            gap_q   <= '0;
            polls_q <= '0;
        end else if (check_now && miss) begin
            polls_q <= polls_q + 1'b1;
            gap_q   <= GAP_W'(POLL_GAP - 1);
        end else if (gap_q != '0) begin
            gap_q   <= gap_q - 1'b1;
        end
    end
endmodule

// File: rtl/kbcs_byte_buf.sv
`timescale 1ns/1ps
// Module: parameter/response byte buffer. It is loaded in full on load,
// and one slot is overwritten per wr_en. It gives combinational access to
// one slot and exposes the whole buffer flat. Load has priority over write.
module kbcs_byte_buf #(
    parameter int N     = 15,
    parameter int W     = 8,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [N*W-1:0]   load_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [W-1:0]     wr_byte,
    output logic [W-1:0]     rd_byte,
    output logic [N*W-1:0]   flat
);
    logic [W-1:0] slot_q [N];

    for (genvar g = 0; g < N; g++) begin : g_slot
        // Hold one byte: bulk load, or targeted overwrite.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (load)
                slot_q[g] <= load_data[g*W +: W];
            else if (wr_en && idx == IDX_W'(g))
                slot_q[g] <= wr_byte;
        end
        assign flat[g*W +: W] = slot_q[g];
    end

    // Select the slot addressed by idx; out-of-range reads return zero.
    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < N; i++)
            if (idx == IDX_W'(i))
                rd_byte = slot_q[i];
    end
endmodule

// File: rtl/kbcs_ctrl.sv
`timescale 1ns/1ps
// Module: transaction state machine. It walks the opcode, the parameter
// writes and the response reads. Strobes are decided in the same cycle
// from the live status byte, on cycles when the poll timer says a check
// is due. Assumes the controller updates status only on clock edges.
module kbcs_ctrl
    import kbcs_pkg::*;
#(
    parameter logic [BYTE_W-1:0] LOOP_OP = 8'hD3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [15:0]       cmd_word,
    input  logic              loop_disable,
    input  logic [7:0]        status,
    input  logic [BYTE_W-1:0] rdata,
    input  logic              check_now,
    input  logic              expired,
    input  logic [BYTE_W-1:0] buf_byte,
    output logic              timer_restart,
    output logic              timer_miss,
    output logic              buf_load,
    output logic              buf_wr,
    output logic [IDX_W-1:0]  buf_idx,
    output logic [BYTE_W-1:0] buf_wbyte,
    output logic              cmd_wr,
    output logic              data_wr,
    output logic [BYTE_W-1:0] wdata,
    output logic              data_rd,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [1:0]        err_code
);
    phase_t            phase_q;
    err_code_t         code_q;
    logic [BYTE_W-1:0] op_q;
    logic [CNT_W-1:0]  nwr_q, nrd_q;
    logic [IDX_W-1:0]  idx_q;
    logic              loop_q;

    cmd_word_t cw;
    logic waiting, ready, src_bad, fire, abort_src, accept, is_loop;
    logic unused_status;

    assign cw            = cmd_word_t'(cmd_word);
    assign is_loop       = (cw.op == LOOP_OP);
    assign unused_status = ^{status[7:6], status[4:2]};

    // Decide readiness, strobes and timer control for the current cycle.
    always_comb begin
        waiting   = (phase_q == PH_CMD) || (phase_q == PH_PARAM) || (phase_q == PH_RESP);
        ready     = (phase_q == PH_RESP) ? status[ST_OBF] : !status[ST_IBF];
        src_bad   = (phase_q == PH_RESP) && loop_q && !status[ST_AUX];
        fire      = waiting && check_now && ready && !src_bad;
        abort_src = waiting && check_now && ready && src_bad;
        accept    = (phase_q == PH_IDLE) && start;
        cmd_wr    = fire && (phase_q == PH_CMD);
        data_wr   = fire && (phase_q == PH_PARAM);
        data_rd   = fire && (phase_q == PH_RESP);
        wdata     = (phase_q == PH_CMD) ? op_q : buf_byte;
        timer_miss    = waiting && !ready;
        timer_restart = accept || fire;
        buf_load  = accept;
        buf_wr    = data_rd;
        buf_idx   = idx_q;
        buf_wbyte = rdata;
        busy      = (phase_q != PH_IDLE);
        done      = (phase_q == PH_FIN) && (code_q == ERR_NONE);
        err       = (phase_q == PH_FIN) && (code_q != ERR_NONE);
        err_code  = err ? code_q : ERR_NONE;
    end

    // Advance through the transaction phases and keep the command fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            code_q  <= ERR_NONE;
            op_q    <= '0;
            nwr_q   <= '0;
            nrd_q   <= '0;
            idx_q   <= '0;
            loop_q  <= 1'b0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        op_q   <= cw.op;
                        nwr_q  <= cw.n_wr;
                        nrd_q  <= cw.n_rd;
                        idx_q  <= '0;
                        loop_q <= is_loop;
                        if (loop_disable && is_loop) begin
                            code_q  <= ERR_REJECT;
                            phase_q <= PH_FIN;
                        end else begin
                            code_q  <= ERR_NONE;
                            phase_q <= PH_CMD;
                        end
                    end
                end
                PH_CMD, PH_PARAM, PH_RESP: begin
                    if (expired) begin
                        code_q  <= ERR_TIMEOUT;
                        phase_q <= PH_FIN;
                    end else if (abort_src) begin
                        code_q  <= ERR_SOURCE;
                        phase_q <= PH_FIN;
                    end else if (fire) begin
                        if (phase_q == PH_CMD) begin
                            idx_q <= '0;
                            if (nwr_q != '0)      phase_q <= PH_PARAM;
                            else if (nrd_q != '0) phase_q <= PH_RESP;
                            else                  phase_q <= PH_FIN;
                        end else if (phase_q == PH_PARAM) begin
                            if (idx_q == nwr_q - 1'b1) begin
                                idx_q   <= '0;
                                phase_q <= (nrd_q != '0) ? PH_RESP : PH_FIN;
                            end else begin
                                idx_q <= idx_q + 1'b1;
                            end
                        end else begin
                            if (idx_q == nrd_q - 1'b1) phase_q <= PH_FIN;
                            else                       idx_q   <= idx_q + 1'b1;
                        end
                    end
                end
                PH_FIN:  phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/kbc_cmd_seq.sv
`timescale 1ns/1ps
// Module: top of the keyboard controller command sequencer. Wires the
// phase machine, the poll timer and the byte buffer together. Assumes a
// single host, and a controller whose status changes on clock edges.
module kbc_cmd_seq
    import kbcs_pkg::*;
#(
    parameter int          POLL_GAP  = 50,
    parameter int          MAX_POLLS = 10000,
    parameter logic [7:0]  LOOP_OP   = 8'hD3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [15:0]         cmd_word,
    input  logic [BUF_BITS-1:0] param_in,
    input  logic                loop_disable,
    input  logic [7:0]          kbc_status,
    input  logic [7:0]          kbc_rdata,
    output logic                kbc_cmd_wr,
    output logic                kbc_data_wr,
    output logic [7:0]          kbc_wdata,
    output logic                kbc_data_rd,
    output logic                busy,
    output logic                done,
    output logic                err,
    output logic [1:0]          err_code,
    output logic [BUF_BITS-1:0] buf_out
);
    logic             t_restart, t_miss, t_check, t_expired;
    logic             b_load, b_wr;
    logic [IDX_W-1:0] b_idx;
    logic [7:0]       b_rbyte, b_wbyte;

    kbcs_ctrl #(.LOOP_OP(LOOP_OP)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_word(cmd_word),
        .loop_disable(loop_disable), .status(kbc_status), .rdata(kbc_rdata),
        .check_now(t_check), .expired(t_expired), .buf_byte(b_rbyte),
        .timer_restart(t_restart), .timer_miss(t_miss),
        .buf_load(b_load), .buf_wr(b_wr), .buf_idx(b_idx), .buf_wbyte(b_wbyte),
        .cmd_wr(kbc_cmd_wr), .data_wr(kbc_data_wr), .wdata(kbc_wdata),
        .data_rd(kbc_data_rd), .busy(busy), .done(done), .err(err),
        .err_code(err_code)
    );

    kbcs_poll_timer #(.POLL_GAP(POLL_GAP), .MAX_POLLS(MAX_POLLS)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(t_restart), .miss(t_miss),
        .check_now(t_check), .expired(t_expired)
    );

    kbcs_byte_buf #(.N(BUF_N), .W(BYTE_W), .IDX_W(IDX_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .load(b_load), .load_data(param_in),
        .wr_en(b_wr), .idx(b_idx), .wr_byte(b_wbyte), .rd_byte(b_rbyte),
        .flat(buf_out)
    );
endmodule

// File: rtl/kbc_cmd_seq_chk.sv
`timescale 1ns/1ps
// Module: property checker for kbc_cmd_seq, attached with bind.
module kbc_cmd_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [7:0] status,
    input logic       cmd_wr,
    input logic       data_wr,
    input logic       data_rd,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic [1:0] err_code
);
    AST_ONE_STROBE:   assert property (@(posedge clk) disable iff (!rst_n) $countones({cmd_wr, data_wr, data_rd}) <= 1); // R10
    AST_STROBE_BUSY:  assert property (@(posedge clk) disable iff (!rst_n) (cmd_wr || data_wr || data_rd) |-> busy); // R10
    AST_CMD_GATED:    assert property (@(posedge clk) disable iff (!rst_n) cmd_wr |-> !status[1]); // R2
    AST_PARAM_GATED:  assert property (@(posedge clk) disable iff (!rst_n) data_wr |-> !status[1]); // R3
    AST_READ_GATED:   assert property (@(posedge clk) disable iff (!rst_n) data_rd |-> status[0]); // R4
    AST_PULSE_EXCL:   assert property (@(posedge clk) disable iff (!rst_n) !(done && err)); // R9
    AST_PULSE_SHORT:  assert property (@(posedge clk) disable iff (!rst_n) (done || err) |=> !(done || err)); // R9
    AST_PULSE_BUSY:   assert property (@(posedge clk) disable iff (!rst_n) (done || err) |-> busy); // R9
    AST_BUSY_START:   assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start)); // R9
    AST_REJECT_FAST:  assert property (@(posedge clk) disable iff (!rst_n) (err && err_code == 2'd3) |-> ($past(start) && !$past(busy))); // R7
endmodule

bind kbc_cmd_seq kbc_cmd_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .status(kbc_status),
    .cmd_wr(kbc_cmd_wr), .data_wr(kbc_data_wr), .data_rd(kbc_data_rd),
    .busy(busy), .done(done), .err(err), .err_code(err_code)
);

// File: tb/kbc_cmd_seq_bench.sv
`timescale 1ns/1ps
module kbc_cmd_seq_bench;
    localparam int GAP  = 3;
    localparam int MAXP = 4;
    localparam logic [7:0] LOOP = 8'hD3;
    localparam int NB   = 15;
    localparam int BITS = NB * 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [15:0] cmd_word = '0;
    logic [BITS-1:0] param_in = '0;
    logic loop_disable = 1'b0;
    logic [7:0] kbc_status, kbc_rdata, kbc_wdata;
    logic kbc_cmd_wr, kbc_data_wr, kbc_data_rd, busy, done, err;
    logic [1:0] err_code;
    logic [BITS-1:0] buf_out;

    int checks = 0;
    int errors = 0;

    // controller model state
    logic ibf_r = 1'b0, obf_r = 1'b0, aux_r = 1'b0;
    logic [7:0] rdata_r = '0;
    bit ibf_stuck = 1'b0;
    int ibf_lat = 1, obf_lat = 1, ibf_cnt = 0, obf_cnt = 0;
    logic [8:0] resp_q [$];

    assign kbc_status = {2'b00, aux_r, 3'b000, ibf_r | ibf_stuck, obf_r};
    assign kbc_rdata  = rdata_r;

    always #10 clk = ~clk;

    kbc_cmd_seq #(.POLL_GAP(GAP), .MAX_POLLS(MAXP), .LOOP_OP(LOOP)) u_kbc_cmd_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_word(cmd_word),
        .param_in(param_in), .loop_disable(loop_disable),
        .kbc_status(kbc_status), .kbc_rdata(kbc_rdata),
        .kbc_cmd_wr(kbc_cmd_wr), .kbc_data_wr(kbc_data_wr), .kbc_wdata(kbc_wdata),
        .kbc_data_rd(kbc_data_rd), .busy(busy), .done(done), .err(err),
        .err_code(err_code), .buf_out(buf_out)
    );

    // behavioural controller: input buffer drains after ibf_lat edges,
    // queued responses appear obf_lat edges after the previous one is read
    always @(posedge clk) begin
        if (kbc_cmd_wr || kbc_data_wr) begin
            ibf_r <= 1'b1;
            ibf_cnt = ibf_lat;
        end else if (ibf_r) begin
            if (ibf_cnt <= 1) ibf_r <= 1'b0;
            ibf_cnt = ibf_cnt - 1;
        end
        if (kbc_data_rd) begin
            void'(resp_q.pop_front());
            obf_r <= 1'b0;
            obf_cnt = obf_lat;
        end else if (!obf_r && resp_q.size() != 0) begin
            if (obf_cnt <= 1) begin
                obf_r   <= 1'b1;
                rdata_r <= resp_q[0][7:0];
                aux_r   <= resp_q[0][8];
            end
            obf_cnt = obf_cnt - 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // compare {cmd_wr,data_wr,data_rd,done,err,busy,err_code} this cycle
    task automatic cmp_cycle(input string req, input logic [2:0] stb, input bit d,
                             input bit e, input bit b, input logic [1:0] code);
        logic [7:0] act, exp;
        act = {kbc_cmd_wr, kbc_data_wr, kbc_data_rd, done, err, busy, err_code};
        exp = {stb, d, e, b, code};
        chk(act == exp, req, "cycle outputs", 128'(act), 128'(exp));
    endtask

    task automatic cmp_idle(input string req);
        cmp_cycle(req, 3'b000, 1'b0, 1'b0, 1'b0, 2'd0);
    endtask

    task automatic setup(input int il, input int ol, input bit stuck);
        resp_q.delete();
        obf_r = 1'b0;
        aux_r = 1'b0;
        ibf_lat = il;
        obf_lat = ol;
        obf_cnt = ol;
        ibf_stuck = stuck;
    endtask

    function automatic logic [BITS-1:0] pattern(input logic [7:0] base);
        logic [BITS-1:0] p;
        for (int i = 0; i < NB; i++) p[i*8 +: 8] = base + 8'(i);
        return p;
    endfunction

    // reference model: walks the transaction step by step and compares every cycle
    task automatic run_txn(input logic [15:0] cw, input logic [BITS-1:0] pin,
                           input bit ld, input string tag);
        logic [7:0] eb [NB];
        logic [BITS-1:0] ebf;
        int nw, nr, total, kind, polls;
        bit lp, rdy, stop;
        nw = int'(cw[15:12]);
        nr = int'(cw[11:8]);
        lp = (cw[7:0] == LOOP);
        for (int i = 0; i < NB; i++) eb[i] = pin[i*8 +: 8];
        @(negedge clk);
        start = 1'b1; cmd_word = cw; param_in = pin; loop_disable = ld;
        @(negedge clk);
        start = 1'b0;
        if (ld && lp) begin
            cmp_cycle("R7", 3'b000, 1'b0, 1'b1, 1'b1, 2'd3);
            @(negedge clk);
            cmp_idle("R7");
            return;
        end
        total = 1 + nw + nr;
        stop = 1'b0;
        for (int s = 0; s < total && !stop; s++) begin
            kind = (s == 0) ? 0 : ((s <= nw) ? 1 : 2);
            polls = 0;
            forever begin
                rdy = (kind == 2) ? obf_r : !(ibf_r | ibf_stuck);
                if (rdy && kind == 2 && lp && !aux_r) begin
                    cmp_cycle("R6", 3'b000, 1'b0, 1'b0, 1'b1, 2'd0);
                    @(negedge clk);
                    cmp_cycle("R6", 3'b000, 1'b0, 1'b1, 1'b1, 2'd2);
                    stop = 1'b1;
                    break;
                end
                if (rdy) begin
                    if (kind == 0) begin
                        cmp_cycle("R2", 3'b100, 1'b0, 1'b0, 1'b1, 2'd0);
                        chk(kbc_wdata == cw[7:0], "R2", "opcode byte", 128'(kbc_wdata), 128'(cw[7:0]));
                    end else if (kind == 1) begin
                        cmp_cycle("R3", 3'b010, 1'b0, 1'b0, 1'b1, 2'd0);
                        chk(kbc_wdata == eb[s-1], "R3", "param byte", 128'(kbc_wdata), 128'(eb[s-1]));
                    end else begin
                        cmp_cycle("R4", 3'b001, 1'b0, 1'b0, 1'b1, 2'd0);
                        eb[s-1-nw] = rdata_r;
                    end
                    @(negedge clk);
                    break;
                end
                cmp_cycle("R5", 3'b000, 1'b0, 1'b0, 1'b1, 2'd0);
                polls++;
                if (polls == MAXP) begin
                    @(negedge clk);
                    cmp_cycle("R5", 3'b000, 1'b0, 1'b1, 1'b1, 2'd1);
                    stop = 1'b1;
                    break;
                end
                for (int g = 0; g < GAP - 1; g++) begin
                    @(negedge clk);
                    cmp_cycle("R5", 3'b000, 1'b0, 1'b0, 1'b1, 2'd0);
                end
                @(negedge clk);
            end
        end
        if (!stop) cmp_cycle(tag, 3'b000, 1'b1, 1'b0, 1'b1, 2'd0);
        @(negedge clk);
        cmp_idle(tag);
        for (int i = 0; i < NB; i++) ebf[i*8 +: 8] = eb[i];
        chk(buf_out == ebf, "R4", "buffer contents", 128'(buf_out), 128'(ebf));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_idle("R1");

        // R2 R4: one response byte, from the keyboard side
        setup(2, 2, 1'b0);
        resp_q.push_back({1'b0, 8'h47});
        run_txn(16'h0120, pattern(8'h10), 1'b0, "R4");

        // R3: one parameter byte, no response
        setup(1, 1, 1'b0);
        run_txn(16'h1060, pattern(8'h45), 1'b0, "R3");

        // R8: no parameters, no response
        setup(3, 1, 1'b0);
        run_txn(16'h00AD, pattern(8'h20), 1'b0, "R8");

        // R3 R4: three writes, two reads, slot 2 keeps its loaded value
        setup(4, 3, 1'b0);
        resp_q.push_back({1'b0, 8'hC1});
        resp_q.push_back({1'b1, 8'hC2});
        run_txn(16'h32AB, pattern(8'h30), 1'b0, "R4");

        // R6: loopback returning from the auxiliary side
        setup(1, 2, 1'b0);
        resp_q.push_back({1'b1, 8'h5A});
        run_txn(16'h11D3, pattern(8'h5A), 1'b0, "R6");

        // R6: loopback byte flagged as keyboard data aborts
        setup(1, 2, 1'b0);
        resp_q.push_back({1'b0, 8'h5A});
        run_txn(16'h11D3, pattern(8'h5A), 1'b0, "R6");

        // R7: loopback refused when disabled, no bus activity afterwards
        setup(1, 1, 1'b0);
        run_txn(16'h11D3, pattern(8'h70), 1'b1, "R7");
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            cmp_idle("R7");
        end

        // R7: loop_disable leaves other opcodes untouched
        setup(1, 1, 1'b0);
        resp_q.push_back({1'b0, 8'h99});
        run_txn(16'h0120, pattern(8'h80), 1'b1, "R7");

        // R5: input buffer never drains -> timeout on the opcode write
        setup(1, 1, 1'b1);
        run_txn(16'h0120, pattern(8'h90), 1'b0, "R5");

        // R5: no response ever arrives -> timeout on the read
        setup(1, 1, 1'b0);
        run_txn(16'h0120, pattern(8'hA0), 1'b0, "R5");

        // R9: a start during a busy transaction is ignored
        setup(6, 1, 1'b0);
        fork
            run_txn(16'h1060, pattern(8'hB0), 1'b0, "R9");
            begin
                repeat (4) @(negedge clk);
                start = 1'b1;
                cmd_word = 16'h00EE;
                @(negedge clk);
                start = 1'b0;
            end
        join
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            cmp_idle("R9");
        end

        // R3 R4: full-size transaction, 15 writes and 15 reads
        setup(1, 1, 1'b0);
        for (int i = 0; i < NB; i++) resp_q.push_back({1'b0, 8'hE0 + 8'(i)});
        run_txn(16'hFF12, pattern(8'h01), 1'b0, "R4");

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule